// File: doc/BRIEF.md
# DRAM Bank and Device Command State Tracker

This block follows the command stream sent to a DDR3-class memory device and keeps a copy of the state that the device itself would hold. Each clock cycle it takes one decoded command, a bank select and a row address. It then updates one state machine per bank and one device-wide state machine. It flags any command that the device could not legally accept in its present state. A memory controller can use it to gate its own scheduler. A protocol monitor can use it to reject a bad command stream.

Each bank moves through idle, activating, active, reading, writing and precharging. The activating and precharging phases last for programmable cycle counts. The device as a whole is in one of these states: initialization, ZQ calibration, normal operation, refresh, self refresh, precharge power-down or active power-down. A RESET command returns everything to initialization from any state. The open row of each bank is captured when the bank is activated.

Top module: `dram_cmd_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the device state is 0 (init), every bank state is 0 (idle), every open row is 0 and `illegal_o` is low.
- R2: In init (0), NOP (0) and MRS (13) are accepted and change nothing. ZQCL (14) moves the device to ZQ calibration (1) for `T_ZQ` cycles, then to normal (2). Any other command except RESET raises the flag. Any command other than NOP or RESET during ZQ calibration also raises the flag.
- R3: In normal state, ACT (1) to an idle bank puts that bank in activating (1) for `T_RCD` cycles, then in active (2). It also stores `row_i` as that bank's open row. Other banks are untouched.
- R4: ACT to a bank that is not idle raises the flag and leaves that bank's state and open row unchanged.
- R5: RD (2) or WR (4) to a bank in active, reading or writing moves it to reading (3) or writing (4). To a bank in idle, activating or precharging, either command raises the flag and changes nothing.
- R6: RDA (3) or WRA (5) to an open bank moves it straight into precharging (5). Sent to a bank that is not open, either command raises the flag.
- R7: PRE (6) moves only the selected open bank into precharging for `T_RP` cycles, then to idle. PRE to an idle or precharging bank is accepted and changes nothing. PRE to an activating bank raises the flag.
- R8: PREA (7) puts every open bank into precharging. If any bank is activating, the flag is raised and that bank is left as it is, while the open banks still close.
- R9: REF (8), SRE (9), ZQCL/ZQCS (14/15) and MRS (13) in normal state are legal only when all banks are idle. Otherwise they raise the flag. REF holds refresh (3) for `T_RFC` cycles. ZQCS holds ZQ calibration (1) for `T_ZQ` cycles. Both then return to normal.
- R10: SRE enters self refresh (4), which only SRX (10) leaves. PDE (11) enters precharge power-down (5) if all banks are idle and active power-down (6) otherwise, and only PDX (12) leaves either one. In these states every other command except NOP and RESET raises the flag. In normal state, a stray SRX or PDX also raises the flag.
- R11: RESET (16), from any state, returns the device to init and every bank to idle with open row 0, and never raises the flag.
- R12: `illegal_o` is high for exactly the one cycle after an offending command and is low after any accepted command. Bank commands (1 to 7) are offending whenever the device is not in normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 5 | Decoded command code (NOP=0 … RESET=16) |
| ba_i | input | 3 | Bank select |
| row_i | input | 15 | Row address captured by ACT |
| bank_state_o | output | 24 | Three-bit state per bank, bank b in bits [3b+2:3b] |
| open_row_o | output | 120 | Open row per bank, bank b in bits [15b+14:15b] |
| dev_state_o | output | 3 | Device-wide state code |
| illegal_o | output | 1 | Registered illegal-command flag |

## Verification
The bench sends commands at the edges of each timed phase. One example is a read issued while a bank is still activating: a tracker that counts one cycle short would accept it, and one that counts one cycle long would flag a later read that should pass. Refresh, MRS and power-down entry are sent both with banks open and with all banks idle. A design that checks only the selected bank would wrongly accept a refresh, or would pick the wrong power-down flavour. PREA is sent while one bank is still activating, to confirm that the open banks still close and the activating bank stays as it is. RESET is applied from inside power-down, to show it overrides everything.

// File: rtl/dct_pkg.sv
package dct_pkg;

   typedef enum logic [4:0] {
      C_NOP   = 5'd0,
      C_ACT   = 5'd1,
      C_RD    = 5'd2,
      C_RDA   = 5'd3,
      C_WR    = 5'd4,
      C_WRA   = 5'd5,
      C_PRE   = 5'd6,
      C_PREA  = 5'd7,
      C_REF   = 5'd8,
      C_SRE   = 5'd9,
      C_SRX   = 5'd10,
      C_PDE   = 5'd11,
      C_PDX   = 5'd12,
      C_MRS   = 5'd13,
      C_ZQCL  = 5'd14,
      C_ZQCS  = 5'd15,
      C_RESET = 5'd16
   } cmd_e;

   typedef enum logic [2:0] {
      B_IDLE    = 3'd0,
      B_OPENING = 3'd1,
      B_ACTIVE  = 3'd2,
      B_READING = 3'd3,
      B_WRITING = 3'd4,
      B_CLOSING = 3'd5
   } bank_e;

   typedef enum logic [2:0] {
      D_INIT    = 3'd0,
      D_ZQCAL   = 3'd1,
      D_NORMAL  = 3'd2,
      D_REFRESH = 3'd3,
      D_SELFREF = 3'd4,
      D_PDN_PRE = 3'd5,
      D_PDN_ACT = 3'd6
   } dev_e;

endpackage

// File: rtl/dct_bank_slot.sv
module dct_bank_slot
   import dct_pkg::*;
#(
   parameter int ROW_W = 15,
   parameter int CNT_W = 4,
   parameter int T_RCD = 4,
   parameter int T_RP  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_e             cmd,
   input  logic             sel,
   input  logic             enable,
   input  logic [ROW_W-1:0] row_in,
   output bank_e            state_o,
   output logic [ROW_W-1:0] row_o,
   output logic             bad_o
);
   localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);

   bank_e            st_q, st_d;
   logic [ROW_W-1:0] row_q, row_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             is_open;

   assign is_open = (st_q == B_ACTIVE) || (st_q == B_READING) || (st_q == B_WRITING);

   always_comb begin
      st_d  = st_q;
      row_d = row_q;
      cnt_d = cnt_q;
      bad_o = 1'b0;
      // timed phases advance regardless of the command
      if (st_q == B_OPENING || st_q == B_CLOSING) begin
         if (cnt_q == '0) st_d = (st_q == B_OPENING) ? B_ACTIVE : B_IDLE;
         else             cnt_d = cnt_q - 1'b1;
      end
      if (enable) begin
         case (cmd)
            C_ACT: if (sel) begin
               if (st_q == B_IDLE) begin
                  st_d  = B_OPENING;
                  cnt_d = RCD_LD;
                  row_d = row_in;
               end else bad_o = 1'b1;
            end
            C_RD, C_RDA, C_WR, C_WRA: if (sel) begin
               if (!is_open) bad_o = 1'b1;
               else if (cmd == C_RDA || cmd == C_WRA) begin
                  st_d  = B_CLOSING;
                  cnt_d = RP_LD;
               end else st_d = (cmd == C_RD) ? B_READING : B_WRITING;
            end
            C_PRE, C_PREA: if (sel || cmd == C_PREA) begin
               if (is_open) begin
                  st_d  = B_CLOSING;
                  cnt_d = RP_LD;
               end else if (st_q == B_OPENING) bad_o = 1'b1;
            end
            default: ;
         endcase
      end
      if (cmd == C_RESET) begin
         st_d  = B_IDLE;
         row_d = '0;
         cnt_d = '0;
         bad_o = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= B_IDLE;
         row_q <= '0;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         row_q <= row_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;
   assign row_o   = row_q;
endmodule

// File: rtl/dct_device_fsm.sv
module dct_device_fsm
   import dct_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int T_ZQ  = 8,
   parameter int T_RFC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  cmd_e cmd,
   input  logic all_idle,
   output dev_e state_o,
   output logic normal_o,
   output logic bad_o
);
   localparam logic [CNT_W-1:0] ZQ_LD  = CNT_W'(T_ZQ - 1);
   localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);

   dev_e             st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             quiet;

   assign quiet = (cmd == C_NOP) || (cmd == C_RESET);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      bad_o = 1'b0;
      case (st_q)
         D_INIT: begin
            if (cmd == C_ZQCL) begin
               st_d  = D_ZQCAL;
               cnt_d = ZQ_LD;
            end else if (!quiet && cmd != C_MRS) bad_o = 1'b1;
         end
         D_ZQCAL, D_REFRESH: begin
            if (cnt_q == '0) st_d = D_NORMAL;
            else             cnt_d = cnt_q - 1'b1;
            if (!quiet) bad_o = 1'b1;
         end
         D_NORMAL: begin
            case (cmd)
               C_REF: if (all_idle) begin
                  st_d  = D_REFRESH;
                  cnt_d = RFC_LD;
               end else bad_o = 1'b1;
               C_SRE: if (all_idle) st_d = D_SELFREF;
                      else bad_o = 1'b1;
               C_ZQCL, C_ZQCS: if (all_idle) begin
                  st_d  = D_ZQCAL;
                  cnt_d = ZQ_LD;
               end else bad_o = 1'b1;
               C_MRS: bad_o = !all_idle;
               C_PDE: st_d = all_idle ? D_PDN_PRE : D_PDN_ACT;
               C_SRX, C_PDX: bad_o = 1'b1;
               default: ;
            endcase
         end
         D_SELFREF: begin
            if (cmd == C_SRX) st_d = D_NORMAL;
            else if (!quiet) bad_o = 1'b1;
         end
         default: begin
            if (cmd == C_PDX) st_d = D_NORMAL;
            else if (!quiet) bad_o = 1'b1;
         end
      endcase
      if (cmd == C_RESET) begin
         st_d  = D_INIT;
         cnt_d = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= D_INIT;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o  = st_q;
   assign normal_o = (st_q == D_NORMAL);
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
   import dct_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 15,
   parameter int T_RCD     = 4,
   parameter int T_RP      = 4,
   parameter int T_RFC     = 10,
   parameter int T_ZQ      = 8,
   localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [4:0]                 cmd_i,
   input  logic [BA_W-1:0]            ba_i,
   input  logic [ROW_W-1:0]           row_i,
   output logic [NUM_BANKS*3-1:0]     bank_state_o,
   output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
   output logic [2:0]                 dev_state_o,
   output logic                       illegal_o
);
   localparam int MAX_AB = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int MAX_CD = (T_RFC > T_ZQ) ? T_RFC : T_ZQ;
   localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W  = $clog2(MAX_T + 1);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RFC < 1 || T_ZQ < 1) begin : g_bad_timing
      $error("every timing count must be at least 1");
   end

   cmd_e                 cmd;
   dev_e                 dev_st;
   logic                 dev_normal, dev_bad;
   logic [NUM_BANKS-1:0] bank_bad, bank_idle;
   logic                 illegal_q;

   assign cmd = cmd_e'(cmd_i);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bank_e st;
      dct_bank_slot #(
         .ROW_W (ROW_W),
         .CNT_W (CNT_W),
         .T_RCD (T_RCD),
         .T_RP  (T_RP)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd     (cmd),
         .sel     (ba_i == BA_W'(b)),
         .enable  (dev_normal),
         .row_in  (row_i),
         .state_o (st),
         .row_o   (open_row_o[b*ROW_W +: ROW_W]),
         .bad_o   (bank_bad[b])
      );
      assign bank_state_o[b*3 +: 3] = st;
      assign bank_idle[b]           = (st == B_IDLE);
   end

   dct_device_fsm #(
      .CNT_W (CNT_W),
      .T_ZQ  (T_ZQ),
      .T_RFC (T_RFC)
   ) u_dev (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .all_idle (&bank_idle),
      .state_o  (dev_st),
      .normal_o (dev_normal),
      .bad_o    (dev_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) illegal_q <= 1'b0;
      else        illegal_q <= dev_bad | (|bank_bad);
   end

   assign dev_state_o = dev_st;
   assign illegal_o   = illegal_q;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
   parameter int NUM_BANKS = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [4:0]             cmd_i,
   input logic [NUM_BANKS*3-1:0] bank_state_o,
   input logic [2:0]             dev_state_o,
   input logic                   illegal_o
);
   // NOP never offends
   assert_nop_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 5'd0) |=> !illegal_o);

   // RESET lands in init with all banks idle
   assert_reset_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 5'd16) |=> (dev_state_o == 3'd0 && bank_state_o == '0));

   // refresh is only entered with all banks idle
   assert_ref_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_state_o == 3'd3 && $past(dev_state_o) != 3'd3) |-> $past(bank_state_o) == '0);

   // self refresh is entered only from normal state
   assert_sr_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_state_o == 3'd4) |-> ($past(dev_state_o) == 3'd2 || $past(dev_state_o) == 3'd4));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
      // active is reached only through activating
      assert_act_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_state_o[b*3 +: 3] == 3'd2) |->
            ($past(bank_state_o[b*3 +: 3]) == 3'd1 || $past(bank_state_o[b*3 +: 3]) == 3'd2));
      // idle is reached only by precharging, staying idle or RESET
      assert_idle_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_state_o[b*3 +: 3] == 3'd0 && $past(cmd_i) != 5'd16) |->
            ($past(bank_state_o[b*3 +: 3]) == 3'd0 || $past(bank_state_o[b*3 +: 3]) == 3'd5));
   end
endmodule

bind dram_cmd_tracker dct_checker #(.NUM_BANKS(NUM_BANKS)) u_dct_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_i        (cmd_i),
   .bank_state_o (bank_state_o),
   .dev_state_o  (dev_state_o),
   .illegal_o    (illegal_o)
);

// File: tb/test_dram_cmd_tracker.sv
`timescale 1ns/1ps
module test_dram_cmd_tracker;
   localparam int NB = 8, RW = 15, TRCD = 4, TRP = 4, TRFC = 10, TZQ = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    cmd = '0;
   logic [2:0]    ba = '0;
   logic [RW-1:0] row = '0;
   logic [NB*3-1:0]  bank_state_o;
   logic [NB*RW-1:0] open_row_o;
   logic [2:0]       dev_state_o;
   logic             illegal_o;

   int checks = 0, fails = 0;
   int mb[NB], mr[NB], mc[NB];
   int md = 0, mdc = 0;
   bit mf = 1'b0;

   always #2.5 clk = ~clk;

   dram_cmd_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .T_RCD(TRCD), .T_RP(TRP),
                      .T_RFC(TRFC), .T_ZQ(TZQ)) i_dram_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ba_i(ba), .row_i(row),
      .bank_state_o(bank_state_o), .open_row_o(open_row_o),
      .dev_state_o(dev_state_o), .illegal_o(illegal_o));

   task automatic cmp(string tag);
      logic [NB*3-1:0]  eb;
      logic [NB*RW-1:0] er;
      for (int i = 0; i < NB; i++) begin
         eb[i*3 +: 3]   = 3'(mb[i]);
         er[i*RW +: RW] = RW'(mr[i]);
      end
      checks++;
      if (dev_state_o !== 3'(md)) begin
         fails++; $display("FAIL %s device state act %0d exp %0d", tag, dev_state_o, md);
      end
      checks++;
      if (bank_state_o !== eb) begin
         fails++; $display("FAIL %s bank states act %h exp %h", tag, bank_state_o, eb);
      end
      checks++;
      if (open_row_o !== er) begin
         fails++; $display("FAIL %s open rows act %h exp %h", tag, open_row_o, er);
      end
      checks++;
      if (illegal_o !== mf) begin
         fails++; $display("FAIL %s illegal flag act %0b exp %0b", tag, illegal_o, mf);
      end
   endtask

   // reference model: one clock edge with command c
   task automatic model(int c, int b, int r);
      int  ob[NB];
      int  od;
      bit  allidle, bad;
      od = md; allidle = 1'b1; bad = 1'b0;
      for (int i = 0; i < NB; i++) begin
         ob[i] = mb[i];
         if (mb[i] != 0) allidle = 1'b0;
      end
      if (c == 16) begin
         for (int i = 0; i < NB; i++) begin mb[i] = 0; mr[i] = 0; mc[i] = 0; end
         md = 0; mdc = 0; mf = 1'b0;
         return;
      end
      for (int i = 0; i < NB; i++)
         if (ob[i] == 1 || ob[i] == 5) begin
            mc[i]--;
            if (mc[i] == 0) mb[i] = (ob[i] == 1) ? 2 : 0;
         end
      if (od == 1 || od == 3) begin
         mdc--;
         if (mdc == 0) md = 2;
      end
      if (c >= 1 && c <= 7) begin
         if (od != 2) bad = 1'b1;
         else if (c == 1) begin
            if (ob[b] == 0) begin mb[b] = 1; mc[b] = TRCD; mr[b] = r; end
            else bad = 1'b1;
         end else if (c <= 5) begin
            if (ob[b] >= 2 && ob[b] <= 4) begin
               if (c == 3 || c == 5) begin mb[b] = 5; mc[b] = TRP; end
               else mb[b] = (c == 2) ? 3 : 4;
            end else bad = 1'b1;
         end else begin
            for (int i = 0; i < NB; i++)
               if (c == 7 || i == b) begin
                  if (ob[i] >= 2 && ob[i] <= 4) begin mb[i] = 5; mc[i] = TRP; end
                  else if (ob[i] == 1) bad = 1'b1;
               end
         end
      end else if (c != 0) begin
         case (od)
            0: if (c == 14) begin md = 1; mdc = TZQ; end else if (c != 13) bad = 1'b1;
            2: case (c)
                  8:  if (allidle) begin md = 3; mdc = TRFC; end else bad = 1'b1;
                  9:  if (allidle) md = 4; else bad = 1'b1;
                  14, 15: if (allidle) begin md = 1; mdc = TZQ; end else bad = 1'b1;
                  13: bad = !allidle;
                  11: md = allidle ? 5 : 6;
                  default: bad = 1'b1;
               endcase
            4: if (c == 10) md = 2; else bad = 1'b1;
            5, 6: if (c == 12) md = 2; else bad = 1'b1;
            default: bad = 1'b1;
         endcase
      end
      mf = bad;
   endtask

   task automatic step(int c, int b, int r, string tag);
      cmd = 5'(c); ba = 3'(b); row = RW'(r);
      @(posedge clk);
      model(c, b, r);
      @(negedge clk);
      cmp(tag);
   endtask

   task automatic idle(int n, string tag);
      for (int k = 0; k < n; k++) step(0, 0, 0, tag);
   endtask

   initial begin
      #(5ns * 20000);
      fails++;
      $display("FAIL watchdog expired act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) begin mb[i] = 0; mr[i] = 0; mc[i] = 0; end
      repeat (2) @(negedge clk);
      cmp("R1");
      rst_n = 1'b1;
      step(0, 0, 0, "R1");
      // init phase
      step(2, 0, 0, "R2");
      step(13, 0, 0, "R2");
      step(8, 0, 0, "R2");
      step(14, 0, 0, "R2");
      step(15, 0, 0, "R2");
      idle(8, "R2");
      // activation and access
      step(1, 2, 'h1234, "R3");
      step(2, 2, 0, "R5");
      idle(3, "R3");
      step(2, 2, 0, "R5");
      step(4, 2, 0, "R5");
      step(1, 2, 'h0007, "R4");
      step(2, 5, 0, "R5");
      step(1, 5, 'h4321, "R3");
      step(8, 0, 0, "R9");
      step(13, 0, 0, "R9");
      step(11, 0, 0, "R10");
      step(2, 2, 0, "R10");
      step(12, 0, 0, "R10");
      step(6, 2, 0, "R7");
      step(3, 5, 0, "R6");
      idle(4, "R7");
      step(6, 4, 0, "R7");
      // refresh
      step(8, 0, 0, "R9");
      step(1, 0, 'h0011, "R9");
      idle(10, "R9");
      // precharge all
      step(1, 0, 'h0011, "R8");
      step(1, 7, 'h7fff, "R8");
      step(7, 0, 0, "R8");
      idle(4, "R8");
      step(2, 0, 0, "R5");
      step(7, 0, 0, "R8");
      idle(4, "R8");
      // self refresh and power-down
      step(9, 0, 0, "R10");
      step(2, 0, 0, "R10");
      step(10, 0, 0, "R10");
      step(11, 0, 0, "R10");
      step(10, 0, 0, "R10");
      step(12, 0, 0, "R10");
      step(12, 0, 0, "R10");
      step(15, 0, 0, "R9");
      idle(8, "R9");
      // auto-precharge on a closed bank, flag timing
      step(5, 3, 0, "R6");
      step(0, 0, 0, "R12");
      step(1, 6, 'h0abc, "R12");
      step(1, 6, 'h0def, "R12");
      step(0, 0, 0, "R12");
      // RESET from power-down
      step(1, 3, 'h02aa, "R11");
      idle(4, "R11");
      step(4, 3, 0, "R11");
      step(11, 0, 0, "R11");
      step(16, 0, 0, "R11");
      step(14, 0, 0, "R11");
      idle(2, "R11");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule